// File: doc/BRIEF.md
# PLL Multiplier and Clock-Select Control Registers

This block holds the two bus-visible bytes that steer a clock generator's phase-locked loop. A programming byte stores the VCO multiplier N and the range value L. A control byte stores a PLL-on bit and a bit that selects the VCO clock as the base clock. The block works out the effective multiplier and the PLL enable from these bytes. It also drives a select request to a separate glitch-free clock-switch block.

Writes arrive on a synchronous byte bus clocked by the crystal-derived clock. The block applies the interlocks that keep the clock tree safe:
- the VCO clock cannot be chosen while the PLL is off or L is zero;
- the PLL cannot be switched off while the VCO clock is chosen;
- one write cannot move both control bits at once.

Lock detection is outside the block. It arrives on an input and can be read in the control byte. Reads are combinational on the address.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the PLL-on bit is 0, the select bit is 0 (crystal), stored N is 1 and L is 0. The programming byte reads 0x10 and the control byte reads 0x00 while the lock input is low.
- R2: The programming byte is at address 0, with N in bits 7:4 and L in bits 3:0. It reads back exactly as written, and the range output equals the stored L.
- R3: The multiplier output equals the stored N, except that it shows 1 when the stored N is 0.
- R4: The control byte is at address 1. Bit 0 is PLL-on and bit 1 is the VCO select. Bit 2 reads the lock input and cannot be written. Bits 7:3 read 0 and ignore writes.
- R5: The PLL enable output is high exactly when the PLL-on bit is 1 and L is nonzero.
- R6: A control write that sets the select bit takes no effect on that bit while the PLL-on bit is 0 or L is 0. The PLL-on bit of the same write is still applied.
- R7: A control write that clears the PLL-on bit takes no effect on that bit while the select bit is 1.
- R8: If one control write would change both bits, the select bit keeps its old value. The PLL-on bit follows its own rule.
- R9: The VCO select request output is high exactly when the stored select bit is 1 and the PLL enable is high.
- R10: A cycle with write-enable low, or a write to an address other than 0 or 1, leaves every stored bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address (0 programming, 1 control) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for the addressed register |
| lock_in | input | 1 | Lock indication from the external detector |
| mult_n | output | 4 | Effective VCO multiplier |
| range_l | output | 4 | Stored range value |
| pll_enable | output | 1 | Enable to the analog PLL |
| vco_select | output | 1 | Base-clock select request to the clock switch |

## Verification
The two control-bit updates can land in the same write. Setting PLL-on and VCO-select together from the off state, or clearing both from the selected state, makes the joint-change rule and the on/off interlock act in one cycle. The bench provokes each case with single control writes. It judges the result against a separately written model, reading back both bits together with the enable and select outputs. A range change to zero while the VCO is selected is also checked, to confirm that the enable and the request both drop while the stored select bit stays.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned ADDR_W = 2;

  typedef struct packed {
    logic vco_sel;
    logic pll_on;
  } ctrl_bits_t;
endpackage

// File: rtl/pll_prog_reg.sv
module pll_prog_reg #(
  parameter int unsigned N_W   = 4,
  parameter int unsigned L_W   = 4,
  parameter logic [3:0]  RST_N = 4'd1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  logic [N_W-1:0] wr_n,
  input  logic [L_W-1:0] wr_l,
  output logic [N_W-1:0] n_raw,
  output logic [N_W-1:0] n_eff,
  output logic [L_W-1:0] l_q,
  output logic           l_nz
);
  // zero multiplier behaves exactly as one
  function automatic logic [N_W-1:0] f_eff_mult(input logic [N_W-1:0] n);
    if (n == '0) return N_W'(1);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_raw <= N_W'(RST_N);
      l_q   <= '0;
    end else if (wr_stb) begin
      n_raw <= wr_n;
      l_q   <= wr_l;
    end
  end

  assign n_eff = f_eff_mult(n_raw);
  assign l_nz  = (l_q != '0);

  AST_EFF_N_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    n_eff != '0);  // R3
  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (n_raw == $past(wr_n)) && (l_q == $past(wr_l)));  // R2
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(n_raw) && $stable(l_q));  // R10
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       want_on,
  input  logic       want_sel,
  input  logic       l_nz,
  output ctrl_bits_t state_q,
  output logic       pll_en,
  output logic       sel_req
);
  // named write events, visible to the assertions
  logic on_set_ev, on_clr_ev, sel_set_ev, sel_clr_ev, joint_ev;
  logic sel_set_ok, on_clr_ok;
  ctrl_bits_t state_d;

  assign on_set_ev  = wr_stb &&  want_on  && !state_q.pll_on;
  assign on_clr_ev  = wr_stb && !want_on  &&  state_q.pll_on;
  assign sel_set_ev = wr_stb &&  want_sel && !state_q.vco_sel;
  assign sel_clr_ev = wr_stb && !want_sel &&  state_q.vco_sel;
  assign joint_ev   = (on_set_ev || on_clr_ev) && (sel_set_ev || sel_clr_ev);

  assign sel_set_ok = sel_set_ev && !joint_ev && state_q.pll_on && l_nz;
  assign on_clr_ok  = on_clr_ev && !state_q.vco_sel;

  always_comb begin
    state_d = state_q;
    if (on_set_ev) state_d.pll_on = 1'b1;
    if (on_clr_ok) state_d.pll_on = 1'b0;
    if (sel_set_ok) state_d.vco_sel = 1'b1;
    if (sel_clr_ev && !joint_ev) state_d.vco_sel = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign pll_en  = state_q.pll_on && l_nz;
  assign sel_req = state_q.vco_sel && pll_en;

  AST_SEL_IMPLIES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    state_q.vco_sel |-> state_q.pll_on);  // R6
  AST_SEL_BLOCKED_NO_L: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_set_ev && !l_nz) |=> !state_q.vco_sel);  // R6
  AST_OFF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (on_clr_ev && state_q.vco_sel) |=> state_q.pll_on);  // R7
  AST_NO_JOINT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    joint_ev |=> $stable(state_q.vco_sel));  // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(state_q));  // R10
endmodule

// File: rtl/pll_rd_mux.sv
module pll_rd_mux #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned N_W       = 4,
  parameter int unsigned L_W       = 4,
  parameter int unsigned PROG_ADDR = 0,
  parameter int unsigned CTRL_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_W-1:0]    n_raw,
  input  logic [L_W-1:0]    l_q,
  input  logic              pll_on,
  input  logic              vco_sel,
  input  logic              lock,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned CTRL_PAD = DATA_W - 3;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(PROG_ADDR))      rdata = {n_raw, l_q};
    else if (addr == ADDR_W'(CTRL_ADDR)) rdata = {{CTRL_PAD{1'b0}}, lock, vco_sel, pll_on};
  end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_cfg_pkg::*;
#(
  parameter int unsigned DATA_W    = BYTE_W,
  parameter int unsigned A_W       = ADDR_W,
  parameter int unsigned N_W       = NIB_W,
  parameter int unsigned L_W       = NIB_W,
  parameter int unsigned PROG_ADDR = 0,
  parameter int unsigned CTRL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [A_W-1:0]    bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  output logic [N_W-1:0]    mult_n,
  output logic [L_W-1:0]    range_l,
  output logic              pll_enable,
  output logic              vco_select
);
  logic prog_wr, ctrl_wr, l_nz;
  logic [N_W-1:0] n_raw;
  ctrl_bits_t cstate;

  assign prog_wr = bus_we && (bus_addr == A_W'(PROG_ADDR));
  assign ctrl_wr = bus_we && (bus_addr == A_W'(CTRL_ADDR));

  pll_prog_reg #(.N_W(N_W), .L_W(L_W), .RST_N(4'd1)) u_prog (
    .clk(clk), .rst_n(rst_n), .wr_stb(prog_wr),
    .wr_n(bus_wdata[DATA_W-1 -: N_W]), .wr_l(bus_wdata[L_W-1:0]),
    .n_raw(n_raw), .n_eff(mult_n), .l_q(range_l), .l_nz(l_nz)
  );

  pll_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(ctrl_wr),
    .want_on(bus_wdata[0]), .want_sel(bus_wdata[1]), .l_nz(l_nz),
    .state_q(cstate), .pll_en(pll_enable), .sel_req(vco_select)
  );

  pll_rd_mux #(.DATA_W(DATA_W), .ADDR_W(A_W), .N_W(N_W), .L_W(L_W),
               .PROG_ADDR(PROG_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_rd (
    .addr(bus_addr), .n_raw(n_raw), .l_q(range_l), .pll_on(cstate.pll_on),
    .vco_sel(cstate.vco_sel), .lock(lock_in), .rdata(bus_rdata)
  );

  AST_EN_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_enable |-> (range_l != '0));  // R5
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    vco_select |-> pll_enable);  // R9
endmodule

// File: tb/pll_ctrl_regs_test.sv
module pll_ctrl_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic lock_in = 1'b0;
  logic [3:0] mult_n, range_l;
  logic pll_enable, vco_select;

  int n_total = 0;
  int n_fail = 0;

  // reference model
  logic [3:0] m_n, m_l;
  logic m_on, m_sel;

  always #2 clk = ~clk;

  pll_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
    .mult_n(mult_n), .range_l(range_l), .pll_enable(pll_enable),
    .vco_select(vco_select)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic model_ctrl(input logic [7:0] d);
    logic nxt_on, nxt_sel, both;
    both = (d[0] != m_on) && (d[1] != m_sel);
    nxt_on = m_on;
    if (d[0]) nxt_on = 1'b1;
    else if (!m_sel) nxt_on = 1'b0;
    nxt_sel = m_sel;
    if (!both) begin
      if (!d[1]) nxt_sel = 1'b0;
      else if (m_on && (m_l != 4'd0)) nxt_sel = 1'b1;
    end
    m_on = nxt_on; m_sel = nxt_sel;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(2'd0, d); chk({tag, " R2 prog readback"}, d, {m_n, m_l});
    rd(2'd1, d); chk({tag, " R4 ctrl readback"}, d, {5'b0, lock_in, m_sel, m_on});
    chk({tag, " R3 mult_n"}, {4'b0, mult_n}, {4'b0, (m_n == 4'd0) ? 4'd1 : m_n});
    chk({tag, " R2 range_l"}, {4'b0, range_l}, {4'b0, m_l});
    chk({tag, " R5 pll_enable"}, {7'b0, pll_enable}, {7'b0, m_on && (m_l != 0)});
    chk({tag, " R9 vco_select"}, {7'b0, vco_select}, {7'b0, m_sel && m_on && (m_l != 0)});
  endtask

  task automatic do_prog(input logic [7:0] d, input string tag);
    wr(2'd0, d);
    m_n = d[7:4]; m_l = d[3:0];
    check_all(tag);
  endtask

  task automatic do_ctrl(input logic [7:0] d, input string tag);
    wr(2'd1, d);
    model_ctrl(d);
    check_all(tag);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    m_n = 4'd1; m_l = 4'd0; m_on = 1'b0; m_sel = 1'b0;
    rd(2'd0, d); chk("R1 prog reset", d, 8'h10);
    rd(2'd1, d); chk("R1 ctrl reset", d, 8'h00);
    chk("R1 enable reset", {7'b0, pll_enable}, 8'h00);
    check_all("R1");
  endtask

  task automatic t_prog;
    do_prog(8'h35, "R2 N3L5");
    do_prog(8'h07, "R3 N0");
    chk("R3 N0 shows one", {4'b0, mult_n}, 8'h01);
    do_prog(8'hF0, "R2 L0");
  endtask

  task automatic t_sel_blocked;
    do_ctrl(8'h02, "R6 sel while off");
    do_ctrl(8'h01, "R5 on with L0");
    chk("R5 enable low with L0", {7'b0, pll_enable}, 8'h00);
    do_ctrl(8'h03, "R6 sel with L0");
    chk("R6 sel stays 0", {7'b0, vco_select}, 8'h00);
  endtask

  task automatic t_select_cycle;
    do_prog(8'h45, "R5 L5");
    chk("R5 enable high", {7'b0, pll_enable}, 8'h01);
    do_ctrl(8'h03, "R9 select vco");
    chk("R9 request high", {7'b0, vco_select}, 8'h01);
    do_ctrl(8'h02, "R7 clear on while selected");
    do_ctrl(8'h00, "R8 clear both");
    do_ctrl(8'h01, "R7 deselect");
    do_ctrl(8'h00, "R7 off after deselect");
  endtask

  task automatic t_joint_on;
    do_ctrl(8'h03, "R8 set both from off");
    chk("R8 sel kept", {7'b0, vco_select}, 8'h00);
    do_ctrl(8'h03, "R8 then select");
  endtask

  task automatic t_range_zero;
    do_prog(8'h20, "R9 L to zero while selected");
    chk("R9 request drops", {7'b0, vco_select}, 8'h00);
    do_prog(8'h26, "R9 L back");
  endtask

  task automatic t_ignored;
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'hAB; bus_we = 1'b0;
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h00;
    @(negedge clk);
    check_all("R10 we low");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    check_all("R10 other address");
  endtask

  task automatic t_ctrl_bits;
    logic [7:0] d;
    lock_in = 1'b1;
    do_ctrl(8'hFF, "R4 upper bits");
    rd(2'd1, d); chk("R4 lock visible", d & 8'hFC, 8'h04);
    do_ctrl(8'hF9, "R4 write lock bit");
    lock_in = 1'b0;
    rd(2'd1, d); chk("R4 lock follows input", d[2] ? 8'h1 : 8'h0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_prog;
    t_sel_blocked;
    t_select_cycle;
    t_joint_on;
    t_range_zero;
    t_ignored;
    t_ctrl_bits;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule